// File: doc/BRIEF.md
# Conditional Branch and Call Resolver

This block settles the control-flow outcome of one branch-class instruction per cycle. It receives the opcode, both operand bytes, the two byte-register values the register file read for an indirect jump, the address of the opcode byte, the arithmetic flags, the key-down status and a bit saying whether code is being fetched from on-chip ROM. One cycle later it presents a registered result. The result says whether the opcode is a branch at all and whether the branch is taken. It also gives the 16-bit target, the next program counter, a return-push request with its return address for taken calls, and the number of machine cycles the instruction consumes.

Three branch families are resolved. Conditional calls and conditional direct jumps carry a 16-bit target in the two operand bytes, most significant byte first. Register-indirect jumps form the target from two byte registers, and they are recognised only when bit 7 of the first operand byte is clear. The low nibble of the opcode selects the condition. Stack handling and fetching are left to neighbouring logic.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid`, `res_taken` and `push_req` are 0.
- R2: The condition is the opcode's low nibble. Code 0 is always true. Codes 1..7 are true when, respectively, key-down, low-nibble-zero, high-nibble-zero, zero flag clear, overflow, half carry or carry is set. Codes 9..F are the inverse of codes 1..7.
- R3: Opcodes 0x60..0x67 and 0x69..0x6F are calls, and 0x70..0x77 and 0x79..0x7F are direct jumps. Their target is `{op_b1, op_b2}`.
- R4: Opcodes 0x50..0x57 and 0x59..0x5F with `op_b1[7]`=0 are indirect jumps with target `{reg_hi, reg_lo}`.
- R5: Opcodes 0x58, 0x68, 0x78, any opcode outside the branch ranges, and indirect-range opcodes with `op_b1[7]`=1 give `res_branch`=0, `res_taken`=0, `push_req`=0 and `res_cycles`=0.
- R6: A call takes 16 cycles when taken and 10 when not taken.
- R7: A direct jump takes 10 cycles whether taken or not.
- R8: An unconditional indirect jump (0x50) takes 12 cycles. A conditional one takes 12 cycles when taken and 10 when not.
- R9: When `int_rom` is 1, every branch cycle count is lowered by 6 (2 per byte of the 3-byte instruction).
- R10: A taken call raises `push_req` with `ret_addr` = `pc_in`+3. An untaken call or any jump leaves `push_req` at 0.
- R11: `next_pc` equals the target when taken and `pc_in`+3 (modulo 2^16) for a branch that is not taken.
- R12: Results appear exactly one clock after an `in_valid` cycle, with `res_valid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | First instruction byte |
| op_b1 | input | 8 | Second instruction byte |
| op_b2 | input | 8 | Third instruction byte |
| reg_lo | input | 8 | Register value for target low byte (indirect) |
| reg_hi | input | 8 | Register value for target high byte (indirect) |
| pc_in | input | 16 | Address of the opcode byte |
| flg_zero | input | 1 | Whole-result zero flag |
| flg_lz | input | 1 | Low nibble of last result was zero |
| flg_uz | input | 1 | High nibble of last result was zero |
| flg_ovf | input | 1 | Overflow flag |
| flg_hc | input | 1 | Half-carry flag |
| flg_cy | input | 1 | Carry flag |
| key_down | input | 1 | A key is pressed |
| int_rom | input | 1 | Code fetched from on-chip ROM |
| res_valid | output | 1 | Result valid |
| res_branch | output | 1 | Opcode was a branch |
| res_taken | output | 1 | Branch taken |
| target | output | 16 | Branch target address |
| next_pc | output | 16 | Address of next instruction |
| push_req | output | 1 | Push return address |
| ret_addr | output | 16 | Return address to push |
| res_cycles | output | 5 | Cycles consumed |

## Verification
The condition logic is swept over every jump code in two flag patterns. In one, all flags are clear. In the other, only the flag that the code tests is set. Together they show that each code reads its own flag and that the upper codes invert the lower ones. Calls and indirect jumps are run both taken and untaken, and again with on-chip fetch. This separates the asymmetric cycle counts and the ROM reduction for each family. The code-8 slots and indirect opcodes with the operand selector bit set show that those opcodes are not decoded as branches. A fall-through near the top of the address space checks that the next address wraps.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {K_NONE, K_JUMP, K_CALL, K_IJMP} br_kind_e;

  typedef struct packed {
    logic key;
    logic lz;
    logic uz;
    logic z;
    logic ovf;
    logic hc;
    logic cy;
  } br_flags_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       b1_msb,
  output br_kind_e   kind
);
  logic [3:0] grp;
  logic [3:0] code;
  assign grp  = opcode[7:4];
  assign code = opcode[3:0];

  always_comb begin
    kind = K_NONE;
    if (code != 4'h8) begin
      case (grp)
        4'h5:    kind = b1_msb ? K_NONE : K_IJMP;
        4'h6:    kind = K_CALL;
        4'h7:    kind = K_JUMP;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
(
  input  logic [3:0] code,
  input  br_flags_t  flags,
  output logic       met
);
  logic base;

  always_comb begin
    case (code[2:0])
      3'd0: base = 1'b1;
      3'd1: base = flags.key;
      3'd2: base = flags.lz;
      3'd3: base = flags.uz;
      3'd4: base = ~flags.z;
      3'd5: base = flags.ovf;
      3'd6: base = flags.hc;
      default: base = flags.cy;
    endcase
    met = code[3] ? ~base : base;
  end
endmodule

// File: rtl/br_timing.sv
module br_timing
  import br_pkg::*;
#(
  parameter int CYC_W          = 5,
  parameter int INSTR_BYTES    = 3,
  parameter int SAVE_PER_BYTE  = 2,
  parameter int CYC_SHORT      = 10,
  parameter int CYC_CALL_TAKEN = 16,
  parameter int CYC_IJMP_TAKEN = 12
) (
  input  br_kind_e         kind,
  input  logic             taken,
  input  logic             int_rom,
  output logic [CYC_W-1:0] cycles
);
  localparam int ROM_SAVE = INSTR_BYTES * SAVE_PER_BYTE;

  logic [CYC_W-1:0] base;

  always_comb begin
    case (kind)
      K_CALL:  base = taken ? CYC_W'(CYC_CALL_TAKEN) : CYC_W'(CYC_SHORT);
      K_JUMP:  base = CYC_W'(CYC_SHORT);
      K_IJMP:  base = taken ? CYC_W'(CYC_IJMP_TAKEN) : CYC_W'(CYC_SHORT);
      default: base = '0;
    endcase
    if (kind != K_NONE && int_rom) cycles = base - CYC_W'(ROM_SAVE);
    else                           cycles = base;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int CYC_W          = 5,
  parameter int INSTR_BYTES    = 3,
  parameter int SAVE_PER_BYTE  = 2,
  parameter int CYC_SHORT      = 10,
  parameter int CYC_CALL_TAKEN = 16,
  parameter int CYC_IJMP_TAKEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        op_b1,
  input  logic [7:0]        op_b2,
  input  logic [7:0]        reg_lo,
  input  logic [7:0]        reg_hi,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              flg_zero,
  input  logic              flg_lz,
  input  logic              flg_uz,
  input  logic              flg_ovf,
  input  logic              flg_hc,
  input  logic              flg_cy,
  input  logic              key_down,
  input  logic              int_rom,
  output logic              res_valid,
  output logic              res_branch,
  output logic              res_taken,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              push_req,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [CYC_W-1:0]  res_cycles
);
  br_kind_e         kind;
  br_flags_t        flags;
  logic             met;
  logic             taken_c;
  logic [CYC_W-1:0] cyc_c;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] seq_c;

  assign flags = '{key: key_down, lz: flg_lz, uz: flg_uz, z: flg_zero,
                   ovf: flg_ovf, hc: flg_hc, cy: flg_cy};

  br_decode u_dec (.opcode(opcode), .b1_msb(op_b1[7]), .kind(kind));
  br_cond   u_cond (.code(opcode[3:0]), .flags(flags), .met(met));

  assign taken_c = (kind != K_NONE) && met;

  br_timing #(
    .CYC_W(CYC_W), .INSTR_BYTES(INSTR_BYTES), .SAVE_PER_BYTE(SAVE_PER_BYTE),
    .CYC_SHORT(CYC_SHORT), .CYC_CALL_TAKEN(CYC_CALL_TAKEN),
    .CYC_IJMP_TAKEN(CYC_IJMP_TAKEN)
  ) u_tim (.kind(kind), .taken(taken_c), .int_rom(int_rom), .cycles(cyc_c));

  assign tgt_c = (kind == K_IJMP) ? ADDR_W'({reg_hi, reg_lo})
                                  : ADDR_W'({op_b1, op_b2});
  assign seq_c = pc_in + ADDR_W'(INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_branch <= 1'b0;
      res_taken  <= 1'b0;
      push_req   <= 1'b0;
      target     <= '0;
      next_pc    <= '0;
      ret_addr   <= '0;
      res_cycles <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_branch <= (kind != K_NONE);
        res_taken  <= taken_c;
        push_req   <= taken_c && (kind == K_CALL);
        target     <= tgt_c;
        next_pc    <= taken_c ? tgt_c : seq_c;
        ret_addr   <= seq_c;
        res_cycles <= cyc_c;
      end else begin
        res_taken <= 1'b0;
        push_req  <= 1'b0;
      end
    end
  end

  p_push_needs_taken_r10: assert property (@(posedge clk) disable iff (rst)
    push_req |-> res_taken);
  p_taken_is_branch_r5: assert property (@(posedge clk) disable iff (rst)
    res_taken |-> res_branch);
  p_one_cycle_latency_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_taken_follows_target_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken) |-> (next_pc == target));
  p_nonbranch_zero_cycles_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_branch) |-> (res_cycles == '0));
  p_branch_cycles_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_branch) |-> (res_cycles <= CYC_W'(CYC_CALL_TAKEN)));
endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] opcode = '0, op_b1 = '0, op_b2 = '0, reg_lo = '0, reg_hi = '0;
  logic [15:0] pc_in = '0;
  logic flg_zero = 0, flg_lz = 0, flg_uz = 0, flg_ovf = 0, flg_hc = 0, flg_cy = 0;
  logic key_down = 0, int_rom = 0;
  logic res_valid, res_branch, res_taken, push_req;
  logic [15:0] target, next_pc, ret_addr;
  logic [4:0] res_cycles;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .op_b1(op_b1),
    .op_b2(op_b2), .reg_lo(reg_lo), .reg_hi(reg_hi), .pc_in(pc_in),
    .flg_zero(flg_zero), .flg_lz(flg_lz), .flg_uz(flg_uz), .flg_ovf(flg_ovf),
    .flg_hc(flg_hc), .flg_cy(flg_cy), .key_down(key_down), .int_rom(int_rom),
    .res_valid(res_valid), .res_branch(res_branch), .res_taken(res_taken),
    .target(target), .next_pc(next_pc), .push_req(push_req),
    .ret_addr(ret_addr), .res_cycles(res_cycles));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    flg_zero = 0; flg_lz = 0; flg_uz = 0; flg_ovf = 0; flg_hc = 0; flg_cy = 0;
    key_down = 0;
  endtask

  // present one instruction at a negedge; results are registered at the next posedge
  task automatic issue(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [15:0] pc);
    @(negedge clk);
    opcode = op; op_b1 = b1; op_b2 = b2; pc_in = pc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", "res_valid", int'(res_valid), 1);
  endtask

  task automatic t_reset();
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "res_taken", int'(res_taken), 0);
    chk("R1", "push_req", int'(push_req), 0);
  endtask

  // R2: each jump code, all flags clear, then only its own flag set
  task automatic t_cond_sweep();
    for (int c = 0; c < 16; c++) begin
      if (c == 8) continue;
      for (int pat = 0; pat < 2; pat++) begin
        logic base;
        logic exp_t;
        clear_flags();
        if (pat == 1) begin
          case (c % 8)
            1: key_down = 1;
            2: flg_lz = 1;
            3: flg_uz = 1;
            4: flg_zero = 1;
            5: flg_ovf = 1;
            6: flg_hc = 1;
            7: flg_cy = 1;
            default: ;
          endcase
        end
        if (c % 8 == 0)      base = 1'b1;
        else if (c % 8 == 4) base = (pat == 0);
        else                 base = (pat == 1);
        exp_t = (c >= 8) ? ~base : base;
        issue(8'h70 | 8'(c), 8'h12, 8'h34, 16'h0100);
        chk("R2", $sformatf("jump code %0h pat %0d taken", c, pat), int'(res_taken), int'(exp_t));
        chk("R7", "jump cycles", int'(res_cycles), 10);
        chk("R3", "jump target", int'(target), 16'h1234);
        chk("R11", "jump next_pc", int'(next_pc), exp_t ? 16'h1234 : 16'h0103);
        chk("R10", "jump push", int'(push_req), 0);
      end
    end
    clear_flags();
  endtask

  task automatic t_call();
    flg_cy = 1;
    issue(8'h67, 8'hAB, 8'hCD, 16'h2000);  // call on carry: taken
    chk("R3", "call taken", int'(res_taken), 1);
    chk("R6", "call taken cycles", int'(res_cycles), 16);
    chk("R10", "call push", int'(push_req), 1);
    chk("R10", "call ret_addr", int'(ret_addr), 16'h2003);
    chk("R11", "call next_pc", int'(next_pc), 16'hABCD);
    issue(8'h6F, 8'hAB, 8'hCD, 16'h2000);  // call on not carry: untaken
    chk("R3", "call untaken", int'(res_taken), 0);
    chk("R6", "call untaken cycles", int'(res_cycles), 10);
    chk("R10", "untaken call push", int'(push_req), 0);
    chk("R11", "call fall-through", int'(next_pc), 16'h2003);
    clear_flags();
  endtask

  task automatic t_ijmp();
    reg_lo = 8'h5A; reg_hi = 8'hC3;
    issue(8'h50, 8'h05, 8'h06, 16'h3000);
    chk("R4", "ijmp target", int'(target), 16'hC35A);
    chk("R4", "ijmp taken", int'(res_taken), 1);
    chk("R8", "ijmp uncond cycles", int'(res_cycles), 12);
    flg_zero = 1;
    issue(8'h54, 8'h05, 8'h06, 16'h3000);  // not zero: untaken
    chk("R8", "ijmp untaken cycles", int'(res_cycles), 10);
    chk("R11", "ijmp fall-through", int'(next_pc), 16'h3003);
    issue(8'h5C, 8'h05, 8'h06, 16'h3000);  // zero: taken
    chk("R8", "ijmp cond taken cycles", int'(res_cycles), 12);
    chk("R11", "ijmp next_pc", int'(next_pc), 16'hC35A);
    clear_flags();
  endtask

  task automatic t_nonbranch();
    logic [7:0] ops [4] = '{8'h58, 8'h78, 8'h68, 8'h51};
    for (int i = 0; i < 4; i++) begin
      issue(ops[i], (i == 3) ? 8'h85 : 8'h00, 8'h00, 16'h4000);
      chk("R5", $sformatf("op %0h branch", ops[i]), int'(res_branch), 0);
      chk("R5", $sformatf("op %0h taken", ops[i]), int'(res_taken), 0);
      chk("R5", $sformatf("op %0h cycles", ops[i]), int'(res_cycles), 0);
      chk("R5", $sformatf("op %0h push", ops[i]), int'(push_req), 0);
    end
  endtask

  task automatic t_rom();
    int_rom = 1;
    issue(8'h60, 8'h11, 8'h22, 16'h0500);
    chk("R9", "rom call taken cycles", int'(res_cycles), 10);
    issue(8'h70, 8'h11, 8'h22, 16'h0500);
    chk("R9", "rom jump cycles", int'(res_cycles), 4);
    issue(8'h50, 8'h01, 8'h02, 16'h0500);
    chk("R9", "rom ijmp cycles", int'(res_cycles), 6);
    issue(8'h68, 8'h00, 8'h00, 16'h0500);
    chk("R9", "rom non-branch cycles", int'(res_cycles), 0);
    int_rom = 0;
  endtask

  task automatic t_wrap();
    flg_cy = 1;
    issue(8'h7F, 8'h00, 8'h00, 16'hFFFE);
    chk("R11", "wrap next_pc", int'(next_pc), 16'h0001);
    clear_flags();
    @(negedge clk);
    chk("R12", "valid drops", int'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cond_sweep();
    t_call();
    t_ijmp();
    t_nonbranch();
    t_rom();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule